// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes sixteen interrupt input levels to a set of processor targets. Each input pin owns a 64-bit redirection entry. The entry holds a vector, a delivery mode, a destination mode, a trigger mode, a mask bit and an 8-bit destination ID. Software reaches the entries indirectly. It first writes an index into a select register, then reads or writes a data window register. Both registers sit on a small memory-mapped bus.

Pin inputs pass through a two-flop synchronizer. A rising level on an unmasked pin with a deliverable entry produces one interrupt message. The message carries the vector, the destination ID, a broadcast flag and the resulting per-target mask, and it leaves through a valid/ready handshake. A pin that rises while its entry is masked and level-triggered is remembered as pending. When software later unmasks that entry, the interrupt is replayed, but only if the pin is still high.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Only 4-byte accesses (`bus_size` = 4) at offset 0x000 (select) or 0x010 (window) take effect. Any other size or offset reads as zero and a write there changes nothing. `bus_rdata` is zero whenever `bus_rd` is low.
- R2: The select register stores and reads back all 32 written bits. Its bits 7:0 are the index that window accesses use.
- R3: Window index 0x00 holds a 4-bit ID in bits 27:24. Other written bits are dropped. Index 0x02 reads the same value as index 0x00. Index 0x01 reads (16 << 16) | 0x11 = 0x00100011. Writes to 0x01 and 0x02 are ignored. Unused indices read zero.
- R4: Window index 0x10 + 2p addresses bits 31:0 of pin p's entry, and 0x11 + 2p addresses bits 63:32. A write replaces only the addressed half.
- R5: After reset the select register and the ID are zero, every entry reads 0x0001_0000_0001_0000 (masked), and `msg_valid` is low.
- R6: A message is produced only on a low-to-high change of a pin whose entry has mask bit 16 = 0, destination mode bit 11 = 0 and delivery mode bits 10:8 = 000. The vector comes from bits 7:0 and the destination from bits 63:56. Falling edges and steady levels produce nothing, and so do other delivery or destination modes.
- R7: Destination 0xFF sets `msg_bcast` and sets `msg_tgt_mask` equal to `active_mask`. Any other destination d gives a mask with only bit d set, or zero if d is not below the target count.
- R8: A rise on a pin whose entry is masked with trigger bit 15 = 1 (level) marks the pin pending. A rise on a masked edge-triggered entry (bit 15 = 0) is dropped.
- R9: A table write that leaves a pending entry unmasked clears the pending mark. It then delivers the message if the pin is still high. If the pin is low, nothing is sent.
- R10: While `msg_valid` is high and `msg_ready` is low, the message fields hold steady. Events that arrive during a stall wait in a per-pin request bit and are sent later, lowest pin number first. Message fields are taken from the entry at the time of launch.
- R11: With the output idle, `msg_valid` rises on the fourth rising clock edge after a pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 16 | Asynchronous interrupt levels |
| bus_addr | input | 12 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| active_mask | input | 8 | Targets that take broadcasts |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_dest | output | 8 | Destination ID |
| msg_bcast | output | 1 | Destination is broadcast |
| msg_tgt_mask | output | 8 | Targets that receive the message |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that `active_mask` stays constant while a broadcast message waits for acceptance. The synchronizer only sees a pin change that lasts several cycles. For that reason the stimulus holds every level for at least ten clocks. It also programs or unmasks entries only after the pin levels have settled through the synchronizer. This keeps the result of every event independent of write-versus-pin ordering within a cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    localparam int          ENT_W      = 64;
    localparam int          F_MASK     = 16;
    localparam int          F_TRIG     = 15;
    localparam int          F_DMODE    = 11;
    localparam int          F_DLV      = 8;
    localparam logic [7:0]  IDX_ID     = 8'h00;
    localparam logic [7:0]  IDX_VER    = 8'h01;
    localparam logic [7:0]  IDX_ARB    = 8'h02;
    localparam logic [7:0]  IDX_TBL    = 8'h10;
    localparam logic [7:0]  DEST_ALL   = 8'hFF;
    localparam logic [63:0] ENT_RST    = 64'h0001_0000_0001_0000;

    // Unmasked, physical destination, fixed delivery.
    function automatic logic can_deliver(input logic [ENT_W-1:0] e);
        return !e[F_MASK] && !e[F_DMODE] && (e[F_DLV +: 3] == 3'b000);
    endfunction

    // Masked and level-triggered: a rise is kept as pending.
    function automatic logic keeps_pending(input logic [ENT_W-1:0] e);
        return e[F_MASK] && e[F_TRIG];
    endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      pin_lvl,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [3:0]               bus_size,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [NUM_PINS-1:0]      fire_o,
    output logic [NUM_PINS-1:0][7:0] ent_vec_o,
    output logic [NUM_PINS-1:0][7:0] ent_dst_o
);
    localparam int          PIN_W    = $clog2(NUM_PINS);
    localparam int          SEL_OFF  = 'h00;
    localparam int          WIN_OFF  = 'h10;
    localparam int          TBL_LIM  = 16 + 2 * NUM_PINS;
    localparam logic [31:0] VER_VAL  = 32'((NUM_PINS << 16) | 'h11);

    typedef struct packed {
        logic [31:0]                    sel;
        logic [3:0]                     id;
        logic [NUM_PINS-1:0][ENT_W-1:0] ent;
        logic [NUM_PINS-1:0]            pend;
        logic [NUM_PINS-1:0]            lvl;
    } tbl_st_t;

    tbl_st_t          st_d, st_q, rst_val;
    logic             acc_ok, hit_sel, hit_win, tbl_hit, hi_half, wr_tbl;
    logic [7:0]       idx;
    logic [PIN_W-1:0] tbl_pin;

    always_comb begin
        rst_val     = '0;
        rst_val.ent = {NUM_PINS{ENT_RST}};
    end

    always_comb begin
        st_d      = st_q;
        fire_o    = '0;
        bus_rdata = '0;
        acc_ok    = (bus_size == 4'd4);
        hit_sel   = acc_ok && (bus_addr == ADDR_W'(SEL_OFF));
        hit_win   = acc_ok && (bus_addr == ADDR_W'(WIN_OFF));
        idx       = st_q.sel[7:0];
        tbl_hit   = (idx >= IDX_TBL) && (int'(idx) < TBL_LIM);
        tbl_pin   = PIN_W'(8'(idx - IDX_TBL) >> 1);
        hi_half   = idx[0];
        wr_tbl    = bus_wr && hit_win && tbl_hit;

        // read path
        if (bus_rd && hit_sel) begin
            bus_rdata = st_q.sel;
        end else if (bus_rd && hit_win) begin
            case (idx)
                IDX_ID:  bus_rdata = {4'b0, st_q.id, 24'b0};
                IDX_VER: bus_rdata = VER_VAL;
                IDX_ARB: bus_rdata = {4'b0, st_q.id, 24'b0};
                default: begin
                    for (int p = 0; p < NUM_PINS; p++) begin
                        if (tbl_hit && tbl_pin == PIN_W'(p))
                            bus_rdata = hi_half ? st_q.ent[p][63:32] : st_q.ent[p][31:0];
                    end
                end
            endcase
        end

        // register writes, applied before pin events
        if (bus_wr && hit_sel)
            st_d.sel = bus_wdata;
        if (bus_wr && hit_win && idx == IDX_ID)
            st_d.id = bus_wdata[27:24];

        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_tbl && tbl_pin == PIN_W'(p)) begin
                if (hi_half) st_d.ent[p][63:32] = bus_wdata;
                else         st_d.ent[p][31:0]  = bus_wdata;
                if (st_q.pend[p] && !st_d.ent[p][F_MASK]) begin
                    st_d.pend[p] = 1'b0;
                    if (st_q.lvl[p] && can_deliver(st_d.ent[p]))
                        fire_o[p] = 1'b1;
                end
            end
            if (pin_lvl[p] != st_q.lvl[p]) begin
                st_d.lvl[p] = pin_lvl[p];
                if (pin_lvl[p]) begin
                    if (can_deliver(st_d.ent[p]))
                        fire_o[p] = 1'b1;
                    else if (keeps_pending(st_d.ent[p]))
                        st_d.pend[p] = 1'b1;
                end
            end
            ent_vec_o[p] = st_d.ent[p][7:0];
            ent_dst_o[p] = st_d.ent[p][63:56];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rst_val;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_msg_launch.sv
module irq_msg_launch
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int NUM_TGT  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      fire_i,
    input  logic [NUM_PINS-1:0][7:0] ent_vec_i,
    input  logic [NUM_PINS-1:0][7:0] ent_dst_i,
    input  logic [NUM_TGT-1:0]       active_mask,
    input  logic                     msg_ready,
    output logic                     msg_valid,
    output logic [7:0]               msg_vector,
    output logic [7:0]               msg_dest,
    output logic                     msg_bcast,
    output logic [NUM_TGT-1:0]       msg_tgt_mask
);
    localparam int PIN_W = $clog2(NUM_PINS);

    typedef struct packed {
        logic [NUM_PINS-1:0] req;
        logic                vld;
        logic [7:0]          vec;
        logic [7:0]          dst;
    } lnch_st_t;

    lnch_st_t         st_d, st_q;
    logic             any_req;
    logic [PIN_W-1:0] pick;

    always_comb begin
        st_d    = st_q;
        any_req = 1'b0;
        pick    = '0;
        if (st_q.vld && msg_ready)
            st_d.vld = 1'b0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (st_q.req[p]) begin
                any_req = 1'b1;
                pick    = PIN_W'(p);
            end
        end
        if (any_req && (!st_q.vld || msg_ready)) begin
            st_d.vld       = 1'b1;
            st_d.vec       = ent_vec_i[pick];
            st_d.dst       = ent_dst_i[pick];
            st_d.req[pick] = 1'b0;
        end
        st_d.req = st_d.req | fire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_valid  = st_q.vld;
    assign msg_vector = st_q.vec;
    assign msg_dest   = st_q.dst;
    assign msg_bcast  = (st_q.dst == DEST_ALL);

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        assign msg_tgt_mask[g] = msg_bcast ? active_mask[g] : (st_q.dst == 8'(g));
    end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl #(
    parameter int NUM_PINS = 16,
    parameter int NUM_TGT  = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_size,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_TGT-1:0]  active_mask,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_bcast,
    output logic [NUM_TGT-1:0]  msg_tgt_mask
);
    logic [NUM_PINS-1:0]      pin_lvl;
    logic [NUM_PINS-1:0]      fire;
    logic [NUM_PINS-1:0][7:0] ent_vec;
    logic [NUM_PINS-1:0][7:0] ent_dst;

    irq_pin_sync #(.W(NUM_PINS)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_lvl)
    );

    irq_redir_table #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fire_o    (fire),
        .ent_vec_o (ent_vec),
        .ent_dst_o (ent_dst)
    );

    irq_msg_launch #(.NUM_PINS(NUM_PINS), .NUM_TGT(NUM_TGT)) i_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .ent_vec_i    (ent_vec),
        .ent_dst_i    (ent_dst),
        .active_mask  (active_mask),
        .msg_ready    (msg_ready),
        .msg_valid    (msg_valid),
        .msg_vector   (msg_vector),
        .msg_dest     (msg_dest),
        .msg_bcast    (msg_bcast),
        .msg_tgt_mask (msg_tgt_mask)
    );
endmodule

// File: rtl/irq_redir_ctrl_chk.sv
module irq_redir_ctrl_chk #(
    parameter int NUM_TGT = 8,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [3:0]         bus_size,
    input logic               bus_rd,
    input logic [31:0]        bus_rdata,
    input logic [NUM_TGT-1:0] active_mask,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [7:0]         msg_vector,
    input logic [7:0]         msg_dest,
    input logic               msg_bcast,
    input logic [NUM_TGT-1:0] msg_tgt_mask
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

    p_unicast_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_bcast |-> $countones(msg_tgt_mask) <= 1);

    p_bcast_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_bcast |-> (msg_tgt_mask & ~active_mask) == '0);

    p_bad_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_size != 4'd4 ||
                   (bus_addr != ADDR_W'('h00) && bus_addr != ADDR_W'('h10)))
        |-> bus_rdata == 32'h0);

    p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 32'h0);

    p_bcast_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_bcast |-> msg_dest == 8'hFF);
endmodule

bind irq_redir_ctrl irq_redir_ctrl_chk #(.NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .active_mask  (active_mask),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_vector   (msg_vector),
    .msg_dest     (msg_dest),
    .msg_bcast    (msg_bcast),
    .msg_tgt_mask (msg_tgt_mask)
);

// File: tb/test_irq_redir_ctrl.sv
module test_irq_redir_ctrl;
    // 125 MHz: 8 time-unit period
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_size = 4'd4;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  active_mask = 8'hFF;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_vector;
    logic [7:0]  msg_dest;
    logic        msg_bcast;
    logic [7:0]  msg_tgt_mask;

    always #4 clk = ~clk;

    irq_redir_ctrl i_irq_redir_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active_mask(active_mask),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_bcast(msg_bcast), .msg_tgt_mask(msg_tgt_mask)
    );

    int nchk = 0;
    int nfail = 0;
    int nacc = 0;
    int acc_pin[$];
    bit finished = 0;

    // behavioural reference state
    logic [31:0] mlo [16];
    logic [31:0] mhi [16];
    bit          mpin [16];
    bit          mpend [16];
    bit          mowed [16];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_deliv(input int p);
        return !mlo[p][16] && !mlo[p][11] && mlo[p][10:8] == 3'b000;
    endfunction

    task automatic reg_wr(input logic [11:0] a, input logic [3:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 4'd4;
    endtask

    task automatic reg_rd(input logic [11:0] a, input logic [3:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_size = 4'd4;
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
        reg_wr(12'h000, 4'd4, {24'h0, idx});
        reg_wr(12'h010, 4'd4, d);
        if (idx >= 8'h10 && idx < 8'h30) begin
            int p;
            p = (int'(idx) - 16) / 2;
            if (idx[0]) mhi[p] = d; else mlo[p] = d;
            if (mpend[p] && !mlo[p][16]) begin
                mpend[p] = 0;
                if (mpin[p] && m_deliv(p)) mowed[p] = 1;
            end
        end
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        reg_wr(12'h000, 4'd4, {24'h0, idx});
        reg_rd(12'h010, 4'd4, d);
    endtask

    // no timing: caller aligns to a falling edge
    task automatic set_pin(input int p, input bit v);
        pin_in[p] = v;
        if (v && !mpin[p]) begin
            if (m_deliv(p)) mowed[p] = 1;
            else if (mlo[p][16] && mlo[p][15]) mpend[p] = 1;
        end
        mpin[p] = v;
    endtask

    task automatic prog(input int p, input logic [31:0] lo, input logic [31:0] hi);
        win_wr(8'(16 + 2 * p + 1), hi);
        win_wr(8'(16 + 2 * p), lo);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // message monitor, samples between edges
    always @(negedge clk) begin
        #1;
        if (rst_n && msg_valid && msg_ready && !finished) begin
            int found;
            logic [7:0] exp_tgt;
            found = -1;
            for (int p = 0; p < 16; p++)
                if (mowed[p] && mlo[p][7:0] == msg_vector) found = p;
            if (found < 0) begin
                chk(0, "R10 unexpected message vector", msg_vector, 0);
            end else begin
                logic [7:0] d;
                d = mhi[found][31:24];
                exp_tgt = (d == 8'hFF) ? active_mask : (d < 8 ? 8'(1 << d) : 8'h00);
                chk(msg_dest == d, "R6 destination", msg_dest, d);
                chk(msg_bcast == (d == 8'hFF), "R7 broadcast flag", msg_bcast, d == 8'hFF);
                chk(msg_tgt_mask == exp_tgt, "R7 target mask", msg_tgt_mask, exp_tgt);
                mowed[found] = 0;
                acc_pin.push_back(found);
            end
            nacc++;
        end
    end

    initial begin
        #800000;
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int base;
        for (int p = 0; p < 16; p++) begin
            mlo[p] = 32'h0001_0000; mhi[p] = 32'h0001_0000;
            mpin[p] = 0; mpend[p] = 0; mowed[p] = 0;
        end
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R5 reset state
        chk(msg_valid == 0, "R5 msg_valid after reset", msg_valid, 0);
        reg_rd(12'h000, 4'd4, rd);
        chk(rd == 0, "R5 select reset", rd, 0);
        win_rd(8'h10, rd);
        chk(rd == 32'h0001_0000, "R5 entry low reset", rd, 32'h0001_0000);
        win_rd(8'h2F, rd);
        chk(rd == 32'h0001_0000, "R5 entry high reset", rd, 32'h0001_0000);
        win_rd(8'h00, rd);
        chk(rd == 0, "R5 ID reset", rd, 0);

        // R1 illegal accesses
        reg_wr(12'h000, 4'd4, 32'h0000_0001);
        reg_rd(12'h000, 4'd2, rd);
        chk(rd == 0, "R1 short read", rd, 0);
        reg_rd(12'h004, 4'd4, rd);
        chk(rd == 0, "R1 bad offset read", rd, 0);
        reg_wr(12'h000, 4'd1, 32'h0000_0055);
        reg_wr(12'h020, 4'd4, 32'h0000_0066);
        reg_rd(12'h000, 4'd4, rd);
        chk(rd == 32'h1, "R1 ignored writes keep select", rd, 1);

        // R2 select register
        reg_wr(12'h000, 4'd4, 32'hABCD_0001);
        reg_rd(12'h000, 4'd4, rd);
        chk(rd == 32'hABCD_0001, "R2 select readback", rd, 32'hABCD_0001);
        reg_rd(12'h010, 4'd4, rd);
        chk(rd == 32'h0010_0011, "R2 index from low byte", rd, 32'h0010_0011);

        // R3 identification registers
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd(8'h00, rd);
        chk(rd == 32'h0F00_0000, "R3 ID field only", rd, 32'h0F00_0000);
        win_rd(8'h02, rd);
        chk(rd == 32'h0F00_0000, "R3 arbitration mirrors ID", rd, 32'h0F00_0000);
        win_wr(8'h01, 32'h0);
        win_wr(8'h02, 32'h0);
        win_rd(8'h01, rd);
        chk(rd == 32'h0010_0011, "R3 version read-only", rd, 32'h0010_0011);
        win_rd(8'h02, rd);
        chk(rd == 32'h0F00_0000, "R3 arbitration read-only", rd, 32'h0F00_0000);
        win_rd(8'h05, rd);
        chk(rd == 0, "R3 unused index", rd, 0);
        win_rd(8'h30, rd);
        chk(rd == 0, "R3 past table end", rd, 0);

        // R4 half writes
        win_wr(8'h13, 32'hDEAD_BEEF);
        win_rd(8'h12, rd);
        chk(rd == 32'h0001_0000, "R4 low half untouched", rd, 32'h0001_0000);
        win_rd(8'h13, rd);
        chk(rd == 32'hDEAD_BEEF, "R4 high half written", rd, 32'hDEAD_BEEF);
        win_wr(8'h13, 32'h0001_0000);

        // R6/R11/R10 unicast, latency and hold
        prog(3, 32'h0000_0043, 32'h0200_0000);
        msg_ready = 1'b0;
        @(negedge clk);
        set_pin(3, 1);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            #1;
            chk(msg_valid == (k == 4), "R11 latency", msg_valid, k == 4);
        end
        wait_clk(5);
        #1;
        chk(msg_valid && msg_vector == 8'h43, "R10 held under stall", msg_vector, 8'h43);
        @(negedge clk);
        msg_ready = 1'b1;
        wait_clk(3);
        chk(nacc == 1, "R6 one message on rise", nacc, 1);
        @(negedge clk); set_pin(3, 0);
        wait_clk(10);
        chk(nacc == 1, "R6 falling edge silent", nacc, 1);

        // R6 non-deliverable modes
        prog(4, 32'h0000_0144, 32'h0);
        prog(5, 32'h0000_0845, 32'h0);
        @(negedge clk); set_pin(4, 1); set_pin(5, 1);
        wait_clk(10);
        chk(nacc == 1, "R6 other delivery/destination modes", nacc, 1);

        // R7 broadcast and out-of-range unicast
        active_mask = 8'h5A;
        prog(6, 32'h0000_0046, 32'hFF00_0000);
        @(negedge clk); set_pin(6, 1);
        wait_clk(10);
        chk(nacc == 2 && acc_pin[$] == 6, "R7 broadcast delivered", nacc, 2);
        prog(13, 32'h0000_004D, 32'h0900_0000);
        @(negedge clk); set_pin(13, 1);
        wait_clk(10);
        chk(nacc == 3 && acc_pin[$] == 13, "R7 unicast beyond targets", nacc, 3);

        // R8/R9 masked level pending and replay
        prog(7, 32'h0001_8047, 32'h0);
        @(negedge clk); set_pin(7, 1);
        wait_clk(10);
        chk(nacc == 3, "R8 masked level held", nacc, 3);
        win_wr(8'h1E, 32'h0000_8047);
        wait_clk(10);
        chk(nacc == 4 && acc_pin[$] == 7, "R9 replay on unmask", nacc, 4);

        prog(8, 32'h0001_8048, 32'h0);
        @(negedge clk); set_pin(8, 1);
        wait_clk(10);
        @(negedge clk); set_pin(8, 0);
        wait_clk(10);
        win_wr(8'h20, 32'h0000_8048);
        wait_clk(10);
        chk(nacc == 4, "R9 dropped when pin low", nacc, 4);

        prog(9, 32'h0001_0049, 32'h0);
        @(negedge clk); set_pin(9, 1);
        wait_clk(10);
        win_wr(8'h22, 32'h0000_0049);
        wait_clk(10);
        chk(nacc == 4, "R8 masked edge dropped", nacc, 4);

        // R10 queued events under stall, ascending order
        prog(10, 32'h0000_004A, 32'h0100_0000);
        prog(11, 32'h0000_004B, 32'h0100_0000);
        prog(12, 32'h0000_004C, 32'h0100_0000);
        msg_ready = 1'b0;
        @(negedge clk); set_pin(12, 1); set_pin(11, 1); set_pin(10, 1);
        wait_clk(20);
        @(negedge clk); msg_ready = 1'b1;
        wait_clk(10);
        chk(nacc == 7, "R10 none lost", nacc, 7);
        base = acc_pin.size() - 3;
        chk(acc_pin[base] == 10 && acc_pin[base+1] == 11 && acc_pin[base+2] == 12,
            "R10 ascending order", acc_pin[base], 10);

        begin
            int owed;
            owed = 0;
            for (int p = 0; p < 16; p++) owed += mowed[p];
            chk(owed == 0, "R10 all expected messages seen", owed, 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule